// File: doc/BRIEF.md
# Page Descriptor Accessed/Dirty Status Updater

This block sits between a device request and the next translation stage. For each request it receives the intent (read or write), the address of the 64-bit page descriptor that governs the access, and the copy of that descriptor already fetched by the walker. It also receives a two-bit per-device tracking selector and two capability flags. It decides whether the access may go on. When the descriptor's accessed or dirty status bits must be raised, it raises them in memory.

A raise never trusts the fetched copy alone. The block takes a lock on a simple 64-bit memory port and reads the descriptor again under that lock. It recomputes the need from what it just read. Only then does it write the merged value and drop the lock. If the fresh copy no longer needs a change, the lock is dropped with no write. Each request ends with a one-cycle completion pulse and a status code. The request kind (ordinary memory access or address-translation request) makes no difference: both follow the same flow and differ only in the intent they carry.

Top module: `pgd_ad_updater`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Every request produces exactly one `done` pulse lasting one cycle. No lock is held while idle.
- R2: A descriptor address whose low three bits are not all zero completes with `done_status` = 2'b10. The memory port is not touched and the lock is not taken.
- R3: A fetched descriptor with bit 0 (present) clear completes with `done_status` = 2'b01. No lock, read or write occurs.
- R4: Selector `track` = 2'b00 or 2'b10 means off, 2'b01 means accessed-only and 2'b11 means accessed-plus-dirty. Any tracking requires `cap_host_access`. Dirty tracking also requires `cap_host_dirty`; without it, 2'b11 acts as accessed-only. With tracking off, the block never updates.
- R5: The accessed bit is bit 5 and the dirty bit is bit 6. Accessed is raised on any access when it is clear and accessed tracking is on. Dirty is raised on a write when it is clear and dirty tracking is on; accessed is raised with it. The written word is the locked re-read word with only these bits added.
- R6: When the fetched descriptor is present and needs no change, the request completes with status 2'b00 without taking the lock.
- R7: An update runs in this order: lock request, wait for grant, exactly one 64-bit read, at most one 64-bit write, release. Reads and writes occur only while the lock is held.
- R8: If the locked re-read shows that no bit needs raising any more, the lock is released without a write and the status is 2'b00.
- R9: If the locked re-read shows the present bit clear, the lock is released without a write and the status is 2'b01.
- R10: A request that is allowed to continue ends with status 2'b00. Code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | Request carries write intent (else read) |
| req_addr | input | ADDR_W | Byte address of the descriptor |
| req_desc | input | 64 | Descriptor as fetched by the walker |
| track | input | 2 | Per-device tracking selector |
| cap_host_access | input | 1 | Accessed tracking supported |
| cap_host_dirty | input | 1 | Dirty tracking supported |
| mem_lock | output | 1 | Lock request, held for the locked sequence |
| mem_lock_gnt | input | 1 | Lock granted |
| mem_rd | output | 1 | 64-bit read strobe, held until acknowledge |
| mem_wr | output | 1 | 64-bit write strobe, held until acknowledge |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Read or write completed |
| done | output | 1 | One-cycle completion strobe |
| done_status | output | 2 | 00 continue, 01 not present, 10 misaligned |

## Verification
The hardest case to reach is the race that the locked re-check exists for. The descriptor in memory changes between the walker's fetch and the lock, so the fresh copy either no longer needs a change or is no longer present. The bench reaches it by loading its memory model with a word that differs from the `req_desc` it presents. This creates a stale fetched copy without needing a second agent. The bench then checks for the absence of a write, the lock count and the status. A related case uses other nonzero bits in memory that the fetched copy lacks, which shows that the written value comes from the re-read.

// File: rtl/ad_pkg.sv
package ad_pkg;
  localparam int DESC_W     = 64;
  localparam int PRES_BIT   = 0;
  localparam int ACC_BIT    = 5;
  localparam int DIRTY_BIT  = 6;
  localparam int ALIGN_BITS = 3;

  localparam logic [1:0] STAT_PASS     = 2'b00;
  localparam logic [1:0] STAT_NOTPRES  = 2'b01;
  localparam logic [1:0] STAT_MISALIGN = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_LOCK, S_READ, S_EVAL, S_WRITE, S_UNLOCK, S_DONE
  } state_e;

  typedef struct packed {
    logic acc_en;
    logic dirty_en;
  } track_t;
endpackage

// File: rtl/ad_policy.sv
module ad_policy (
  input  logic [1:0]     track,
  input  logic           cap_host_access,
  input  logic           cap_host_dirty,
  output ad_pkg::track_t en
);
  logic sel_acc;
  logic sel_dirty;
  always_comb begin
    sel_acc     = (track == 2'b01) || (track == 2'b11);
    sel_dirty   = (track == 2'b11);
    en.acc_en   = sel_acc && cap_host_access;
    en.dirty_en = sel_dirty && cap_host_access && cap_host_dirty;
  end
endmodule

// File: rtl/ad_eval.sv
module ad_eval #(
  parameter int DESC_W = ad_pkg::DESC_W
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              is_write,
  input  ad_pkg::track_t    en,
  output logic              present,
  output logic              need,
  output logic [DESC_W-1:0] new_desc
);
  logic set_acc;
  logic set_dirty;
  always_comb begin
    present   = desc[ad_pkg::PRES_BIT];
    set_dirty = en.dirty_en && is_write && !desc[ad_pkg::DIRTY_BIT];
    set_acc   = en.acc_en && (!desc[ad_pkg::ACC_BIT] || set_dirty);
    need      = present && (set_acc || set_dirty);
    new_desc  = desc;
    if (set_acc)   new_desc[ad_pkg::ACC_BIT]   = 1'b1;
    if (set_dirty) new_desc[ad_pkg::DIRTY_BIT] = 1'b1;
  end
endmodule

// File: rtl/pgd_ad_updater.sv
module pgd_ad_updater #(
  parameter int ADDR_W = 48,
  parameter int DESC_W = ad_pkg::DESC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [1:0]        track,
  input  logic              cap_host_access,
  input  logic              cap_host_dirty,
  output logic              mem_lock,
  input  logic              mem_lock_gnt,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DESC_W-1:0] mem_wdata,
  input  logic [DESC_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              done,
  output logic [1:0]        done_status
);
  import ad_pkg::*;

  localparam int AL = ALIGN_BITS;

  state_e            state;
  logic [ADDR_W-1:0] addr_q;
  logic [DESC_W-1:0] fetch_q;
  logic [DESC_W-1:0] reread_q;
  logic [DESC_W-1:0] wdata_q;
  logic              write_q;
  logic [1:0]        status_q;
  track_t            en_now;
  track_t            en_q;

  logic [DESC_W-1:0] eval_in;
  logic              ev_present;
  logic              ev_need;
  logic [DESC_W-1:0] ev_new;

  ad_policy u_policy (
    .track           (track),
    .cap_host_access (cap_host_access),
    .cap_host_dirty  (cap_host_dirty),
    .en              (en_now)
  );

  // one evaluator shared by the fetched copy and the locked re-read
  assign eval_in = (state == S_EVAL) ? reread_q : fetch_q;

  ad_eval #(.DESC_W(DESC_W)) u_eval (
    .desc     (eval_in),
    .is_write (write_q),
    .en       (en_q),
    .present  (ev_present),
    .need     (ev_need),
    .new_desc (ev_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      fetch_q  <= '0;
      reread_q <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      en_q     <= '0;
      status_q <= STAT_PASS;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          fetch_q  <= req_desc;
          write_q  <= req_write;
          en_q     <= en_now;
          status_q <= STAT_PASS;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if (addr_q[AL-1:0] != '0) begin
            status_q <= STAT_MISALIGN;
            state    <= S_DONE;
          end else if (!ev_present) begin
            status_q <= STAT_NOTPRES;
            state    <= S_DONE;
          end else if (ev_need) begin
            state    <= S_LOCK;
          end else begin
            state    <= S_DONE;
          end
        end
        S_LOCK: if (mem_lock_gnt) state <= S_READ;
        S_READ: if (mem_ack) begin
          reread_q <= mem_rdata;
          state    <= S_EVAL;
        end
        S_EVAL: begin
          if (!ev_present) begin
            status_q <= STAT_NOTPRES;
            state    <= S_UNLOCK;
          end else if (ev_need) begin
            wdata_q  <= ev_new;
            state    <= S_WRITE;
          end else begin
            state    <= S_UNLOCK;
          end
        end
        S_WRITE:  if (mem_ack) state <= S_UNLOCK;
        S_UNLOCK: state <= S_DONE;
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign mem_lock    = (state == S_LOCK) || (state == S_READ) ||
                       (state == S_EVAL) || (state == S_WRITE);
  assign mem_rd      = (state == S_READ);
  assign mem_wr      = (state == S_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign done        = (state == S_DONE);
  assign done_status = status_q;
endmodule

// File: rtl/ad_checker.sv
module ad_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       mem_lock,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [2:0] addr_lo,
  input logic       wdata_pres,
  input logic       wdata_acc,
  input logic       done,
  input logic [1:0] done_status
);
  assert_rd_locked_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> mem_lock);
  assert_wr_locked_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_lock);
  assert_wr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (addr_lo == 3'b000));
  assert_wr_marks_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (wdata_pres && wdata_acc));
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_unlocked_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_lock);
  assert_status_legal_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_status != 2'b11));
  assert_release_then_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_lock) |=> done);
endmodule

bind pgd_ad_updater ad_checker u_ad_checker (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .mem_lock    (mem_lock),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .addr_lo     (mem_addr[2:0]),
  .wdata_pres  (mem_wdata[0]),
  .wdata_acc   (mem_wdata[5]),
  .done        (done),
  .done_status (done_status)
);

// File: tb/tb_pgd_ad_updater.sv
module tb_pgd_ad_updater;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_desc = '0;
  logic [1:0]        track = 2'b00;
  logic              cap_host_access = 1'b1;
  logic              cap_host_dirty = 1'b1;
  logic              mem_lock;
  logic              mem_lock_gnt = 1'b0;
  logic              mem_rd;
  logic              mem_wr;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata = '0;
  logic              mem_ack = 1'b0;
  logic              done;
  logic [1:0]        done_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgd_ad_updater #(.ADDR_W(ADDR_W)) dut (.*);

  // memory model: 16 words, lock granted one half cycle after request
  logic [63:0] mem [16];
  int wr_total = 0, rd_total = 0, lock_total = 0;
  logic lock_prev = 1'b0;

  always @(negedge clk) begin
    mem_lock_gnt <= mem_lock;
    if (mem_lock && !lock_prev) lock_total++;
    lock_prev = mem_lock;
    if ((mem_rd || mem_wr) && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_rd) begin
        mem_rdata <= mem[mem_addr[6:3]];
        rd_total++;
      end
      if (mem_wr) begin
        mem[mem_addr[6:3]] = mem_wdata;
        wr_total++;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct {
    string       tag;
    logic [1:0]  status;
    int          writes, reads, locks;
    int          wr0, rd0, lk0;
    int          idx;
    logic [63:0] word;
  } exp_t;
  exp_t sb[$];

  int n_cmp = 0, n_bad = 0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        if (sb.size() == 0) begin
          check("R1", "unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          check(e.tag, "status", done_status, e.status);
          check(e.tag, "writes", wr_total - e.wr0, e.writes);
          check(e.tag, "reads", rd_total - e.rd0, e.reads);
          check(e.tag, "locks", lock_total - e.lk0, e.locks);
          check(e.tag, "memory word", mem[e.idx], e.word);
        end
      end
    end
  end

  // driver
  task automatic run(string tag, int idx, logic [2:0] lo, logic wr, logic [1:0] trk,
                     logic ca, logic cd, logic [63:0] fetched, logic [63:0] pre,
                     logic [1:0] est, int ew, int er, int el, logic [63:0] eword);
    exp_t e;
    mem[idx] = pre;
    e.tag = tag; e.status = est; e.writes = ew; e.reads = er; e.locks = el;
    e.wr0 = wr_total; e.rd0 = rd_total; e.lk0 = lock_total;
    e.idx = idx; e.word = eword;
    sb.push_back(e);
    @(negedge clk);
    check("R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; track = trk;
    cap_host_access = ca; cap_host_dirty = cd;
    req_addr = {40'h0, 1'b0, idx[3:0], lo}; req_desc = fetched;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "ready while busy", req_ready, 0);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [63:0] P = 64'h1;
  localparam logic [63:0] A = 64'h20;
  localparam logic [63:0] D = 64'h40;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ready", req_ready, 1);
    check("R1", "reset done", done, 0);
    check("R1", "reset lock", mem_lock, 0);
    rst = 1'b0;
    // R5: read raises accessed
    run("R5", 1, 0, 0, 2'b11, 1, 1, P, P, 2'b00, 1, 1, 1, P|A);
    // R5: write raises dirty when accessed already set
    run("R5", 2, 0, 1, 2'b11, 1, 1, P|A, P|A, 2'b00, 1, 1, 1, P|A|D);
    // R5/R7: write raises both, other bits of re-read word preserved
    run("R7", 3, 0, 1, 2'b11, 1, 1, P, 64'h00AB_CD00_0000_1001, 2'b00, 1, 1, 1,
        64'h00AB_CD00_0000_1061);
    // R4: accessed-only mode ignores dirty on write
    run("R4", 4, 0, 1, 2'b01, 1, 1, P|A, P|A, 2'b00, 0, 0, 0, P|A);
    // R4: no dirty capability -> accessed only
    run("R4", 5, 0, 1, 2'b11, 1, 0, P, P, 2'b00, 1, 1, 1, P|A);
    // R4: no access capability -> off
    run("R4", 6, 0, 1, 2'b11, 0, 1, P, P, 2'b00, 0, 0, 0, P);
    // R4: selector 10 is off
    run("R4", 7, 0, 1, 2'b10, 1, 1, P, P, 2'b00, 0, 0, 0, P);
    // R4: selector 00 is off
    run("R4", 8, 0, 0, 2'b00, 1, 1, P, P, 2'b00, 0, 0, 0, P);
    // R2: misaligned address
    run("R2", 9, 3'b100, 1, 2'b11, 1, 1, P, P, 2'b10, 0, 0, 0, P);
    // R3: not present in fetched copy
    run("R3", 10, 0, 1, 2'b11, 1, 1, 64'h0, 64'h0, 2'b01, 0, 0, 0, 64'h0);
    // R6/R10: nothing to raise, continue without lock
    run("R6", 11, 0, 1, 2'b11, 1, 1, P|A|D, P|A|D, 2'b00, 0, 0, 0, P|A|D);
    // R8: stale fetch, memory already marked -> no write
    run("R8", 12, 0, 0, 2'b11, 1, 1, P, P|A, 2'b00, 0, 1, 1, P|A);
    // R9: stale fetch, memory no longer present -> fault, no write
    run("R9", 13, 0, 1, 2'b11, 1, 1, P, 64'h0, 2'b01, 0, 1, 1, 64'h0);
    // R10: continuation status after an update
    run("R10", 14, 0, 0, 2'b01, 1, 0, P|D, P|D, 2'b00, 1, 1, 1, P|D|A);
    finish_run();
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_run();
  end
endmodule